// File: doc/BRIEF.md
# Auto-Reload Compare-Match PWM Timer

This block generates one pulse-width-modulated output from an up-counter that runs from a programmed reload value to all-ones. After each wrap past all-ones, the counter reloads. The distance from the reload value to all-ones sets the period. A compare value inside that range marks where the active phase ends. An optional power-of-two prescaler slows the rate at which the counter advances.

Software programs the reload and compare values through a small write port while the timer is stopped, then starts it through the control register. On every start the counter is primed one step below all-ones, so the first wrap happens two counter ticks later and makes the output active. A polarity bit selects whether the active level is high or low. While the timer is stopped the output stays at its inactive level. Writes that try to change the reload or compare value while the timer runs are dropped and raise a sticky error flag.

Top module: `arpwm_timer`

## Requirements
- R1: After reset the timer is stopped, `pwm_out` is 0 and `wr_err` is 0.
- R2: A control write with bit 0 set while stopped starts the timer and primes the counter to all-ones minus one. Without prescaling, `pwm_out` stays inactive for two clock cycles after the write edge and becomes active on the third.
- R3: On every counter tick at all-ones the counter reloads the reload value (`wr_sel` = 0), so one period lasts all-ones − reload + 1 ticks.
- R4: The active phase lasts compare − reload + 1 ticks and the inactive phase lasts all-ones − compare ticks, where the compare value is written with `wr_sel` = 1.
- R5: Control bit 1 inverts the output. The inactive level equals this bit, both while running and while stopped.
- R6: Control bit 2 enables the prescaler and control bits 5:3 hold n. When the prescaler is enabled the counter ticks once every 2^(n+1) clocks. When it is disabled the counter ticks every clock.
- R7: A reload or compare write with a different value while running is ignored and sets `wr_err`, which stays set until reset.
- R8: Rewriting the current reload or compare value while running leaves `wr_err` clear and the waveform unchanged.
- R9: A control write with bit 0 clear stops the timer. The counter then holds and the output sits at its inactive level. A later start primes the counter again.
- R10: With reload = compare = all-ones − 1, the shortest period of 2 ticks gives 1 active tick and 1 inactive tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Target: 0 reload, 1 compare, 2 control, 3 none |
| wr_data | input | CW | Write data |
| pwm_out | output | 1 | PWM output |
| wr_err | output | 1 | Sticky flag for a blocked write while running |

## Verification
The bench builds the timer with an 8-bit counter (CW = 8), so all-ones is 0xFF. With that width, wraps, reloads and complete periods, including prescaled ones, take only tens to hundreds of cycles, and every phase length can be measured exactly. The 3-bit prescaler field keeps its default width, and the bench uses divide-by-2 and divide-by-4. The reload value 0xFE reaches the two-tick minimum period.

// File: rtl/arpwm_timer.sv
module arpwm_timer #(
  parameter int CW = 32,
  parameter int NW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [CW-1:0] wr_data,
  output logic          pwm_out,
  output logic          wr_err
);
  localparam logic [CW-1:0] TOP   = '1;
  localparam logic [CW-1:0] PRIME = TOP - 1'b1;
  localparam int PSW = 1 << NW;

  logic [CW-1:0]  cnt, ld, mt;
  logic           run, inv, pen, lvl, armed;
  logic [NW-1:0]  pn;
  logic [PSW-1:0] psc, mask;

  wire sel_ld = wr_en && (wr_sel == 2'd0);
  wire sel_mt = wr_en && (wr_sel == 2'd1);
  wire sel_ct = wr_en && (wr_sel == 2'd2);
  wire start  = sel_ct && wr_data[0] && !run;

  assign mask = {PSW{1'b1}} >> (PSW - 1 - int'(pn));
  wire tick = run && (!pen || ((psc & mask) == mask));

  assign pwm_out = run ? (lvl ^ inv) : inv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ld <= '0; mt <= '0; wr_err <= 1'b0;
      run <= 1'b0; inv <= 1'b0; pen <= 1'b0; pn <= '0;
    end else begin
      if (sel_ld && !run) ld <= wr_data;
      if (sel_mt && !run) mt <= wr_data;
      if ((sel_ld && run && wr_data != ld) || (sel_mt && run && wr_data != mt))
        wr_err <= 1'b1;
      if (sel_ct && !(run && wr_data[0])) begin
        run <= wr_data[0];
        inv <= wr_data[1];
        pen <= wr_data[2];
        pn  <= wr_data[3 +: NW];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0; lvl <= 1'b0; armed <= 1'b0; psc <= '0;
    end else if (start) begin
      cnt <= PRIME; lvl <= 1'b0; armed <= 1'b0; psc <= '0;
    end else if (run) begin
      psc <= psc + 1'b1;
      if (tick) begin
        if (cnt == TOP) begin
          cnt <= ld; lvl <= 1'b1; armed <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
          if (armed && cnt == mt) lvl <= 1'b0;
        end
      end
    end
  end

  AST_PRIME_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (cnt == PRIME && !lvl)); // R2
  AST_RELOAD_AT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt == TOP) |=> (cnt == $past(ld) && lvl)); // R3
  AST_LOAD_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_ld && run) |=> $stable(ld)); // R7
  AST_MATCH_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_mt && run) |=> $stable(mt)); // R7
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    wr_err |=> wr_err); // R7
  AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !$past(run)) |-> $stable(cnt)); // R9
endmodule

// File: tb/tb_arpwm_timer.sv
`timescale 1ns/1ps
module tb_arpwm_timer;
  localparam int CW = 8;
  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [1:0] wr_sel = 0;
  logic [CW-1:0] wr_data = 0;
  logic pwm_out, wr_err;
  int total = 0, bad = 0;

  arpwm_timer #(.CW(CW), .NW(3)) dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .pwm_out(pwm_out), .wr_err(wr_err));

  always #2.5 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [CW-1:0] d);
    @(negedge clk); wr_en = 1; wr_sel = s; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic measure(input logic act, output int a, output int b);
    int g = 0;
    a = 0; b = 0;
    while (pwm_out === act && g < 3000) begin @(negedge clk); g++; end
    while (pwm_out !== act && g < 3000) begin @(negedge clk); g++; end
    while (pwm_out === act && g < 3000) begin a++; @(negedge clk); g++; end
    while (pwm_out !== act && g < 3000) begin b++; @(negedge clk); g++; end
  endtask

  task automatic t_reset;
    rst_n = 0; wr_en = 0;
    repeat (3) @(negedge clk);
    chk("R1 pwm_out", pwm_out, 0);
    chk("R1 wr_err", wr_err, 0);
    rst_n = 1; @(negedge clk);
  endtask

  task automatic t_prime(input string req);
    wr(2'd2, 8'h01);
    chk({req, " primed cycle0"}, pwm_out, 0);
    @(negedge clk); chk({req, " primed cycle1"}, pwm_out, 0);
    @(negedge clk); chk({req, " first overflow"}, pwm_out, 1);
  endtask

  task automatic t_period;
    int a, b;
    wr(2'd0, 8'hF0); wr(2'd1, 8'hF3);
    t_prime("R2");
    measure(1'b1, a, b);
    chk("R4 active", a, 4); chk("R3 R4 inactive", b, 12);
    wr(2'd2, 8'h00); wr(2'd1, 8'hF8); wr(2'd2, 8'h01);
    measure(1'b1, a, b);
    chk("R4 active F8", a, 9); chk("R3 inactive F8", b, 7);
    wr(2'd2, 8'h00); wr(2'd1, 8'hF3);
  endtask

  task automatic t_prescale;
    int a, b;
    wr(2'd2, 8'h05);
    measure(1'b1, a, b);
    chk("R6 div2 active", a, 8); chk("R6 div2 inactive", b, 24);
    wr(2'd2, 8'h00); wr(2'd2, 8'h0D);
    measure(1'b1, a, b);
    chk("R6 div4 active", a, 16); chk("R6 div4 inactive", b, 48);
    wr(2'd2, 8'h00);
  endtask

  task automatic t_polarity;
    int a, b;
    wr(2'd2, 8'h02);
    repeat (2) @(negedge clk);
    chk("R5 stopped inverted level", pwm_out, 1);
    wr(2'd2, 8'h03);
    measure(1'b0, a, b);
    chk("R5 inverted active low", a, 4); chk("R5 inverted inactive high", b, 12);
    wr(2'd2, 8'h00);
  endtask

  task automatic t_identical;
    int a, b;
    wr(2'd0, 8'hF0); wr(2'd1, 8'hF3); wr(2'd2, 8'h01);
    wr(2'd1, 8'hF3); wr(2'd0, 8'hF0);
    chk("R8 no error on same value", wr_err, 0);
    measure(1'b1, a, b);
    chk("R8 active unchanged", a, 4); chk("R8 inactive unchanged", b, 12);
  endtask

  task automatic t_lock;
    int a, b;
    wr(2'd0, 8'h80);
    chk("R7 error on load write", wr_err, 1);
    wr(2'd1, 8'hFA);
    measure(1'b1, a, b);
    chk("R7 active unchanged", a, 4); chk("R7 inactive unchanged", b, 12);
    wr(2'd2, 8'h00);
    repeat (3) @(negedge clk);
    chk("R7 error sticky", wr_err, 1);
  endtask

  task automatic t_stop;
    int hi = 0;
    wr(2'd2, 8'h01);
    repeat (7) @(negedge clk);
    wr(2'd2, 8'h00);
    for (int i = 0; i < 20; i++) begin
      if (pwm_out) hi++;
      @(negedge clk);
    end
    chk("R9 stopped output inactive", hi, 0);
    t_prime("R9 restart");
    wr(2'd2, 8'h00);
  endtask

  task automatic t_minimum;
    int a, b;
    wr(2'd0, 8'hFE); wr(2'd1, 8'hFE); wr(2'd2, 8'h01);
    measure(1'b1, a, b);
    chk("R10 active", a, 1); chk("R10 inactive", b, 1);
    measure(1'b1, a, b);
    chk("R10 active repeat", a, 1); chk("R10 inactive repeat", b, 1);
    wr(2'd2, 8'h00);
  endtask

  initial begin
    t_reset;
    t_period;
    t_prescale;
    t_polarity;
    t_stop;
    t_minimum;
    t_reset;
    t_identical;
    t_lock;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule